// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register-side half of a memory-mapped serial port. A CPU reaches it through a 4 KB window of 32-bit registers, selected by word index. Bytes from the line side arrive on a valid/ready receive stream and wait in a circular receive queue of configurable depth. The CPU drains the queue one byte per read of the data register. A CPU write to the data register sends one byte out on a valid/ready transmit stream.

A level interrupt is formed from three enable bits. The address and length registers of separate transmit and receive DMA engines are held here and driven out as sideband signals. The engines themselves sit outside the block.

Bus timing: an access is presented for one cycle with `bus_sel` high. For a read, `bus_rdata` and `bus_rvalid` become valid in the following cycle. Receive back-pressure: a byte moves when `rx_valid` and `rx_ready` are both high at a clock edge. `rx_ready` is low while the queue is full or a receive DMA length is outstanding. Transmit: `tx_valid` stays high and `tx_data` stays stable until `tx_ready` is seen at an edge. A new data-register write while a byte is still pending replaces the pending byte.

Top module: `serport_front`

## Requirements
- R1: The register is chosen by word index `bus_addr[11:2]`; all address bits above bit 11 are ignored. Indices: 0 identity, 1 data, 2 queue occupancy, 3 interrupt enable, 4 transmit DMA address, 5 transmit DMA length, 6 receive DMA address, 7 receive DMA length, 8 queue depth.
- R2: Index 0 reads the constant parameter `ID_VALUE`. Index 8 reads the queue depth. Index 5 always reads 0.
- R3: A read of index 1 with a non-empty queue returns the oldest byte in bits [7:0], with zeros above, and removes it. Bytes come out in arrival order. Read data and `bus_rvalid` appear one cycle after the access.
- R4: A read of index 1 with an empty queue returns 0xFFFFFFFF and leaves the occupancy unchanged.
- R5: The queue is circular and wraps past its last slot without loss. Index 2 reads the number of stored bytes.
- R6: `rx_ready` is high exactly when the receive DMA length is 0 and the occupancy is below the depth. A byte is stored when `rx_valid` and `rx_ready` are both high at an edge.
- R7: A `FIFO_DEPTH` parameter of zero or less gives a depth of 16.
- R8: A write to index 1 raises `tx_valid` with `tx_data` equal to the write data bits [7:0]. The byte is held until accepted with `tx_ready`.
- R9: Interrupt enable bits are bit 0 (queue), bit 1 (transmit DMA) and bit 2 (receive DMA); bits above read 0. `irq` is registered and equals (bit0 and occupancy nonzero) or bit1 or (bit2 and receive DMA length zero), one cycle after the state it is computed from.
- R10: Indices 4, 6 and 7 read back what was last written. A write to index 6 also clears the receive DMA length. A write to index 5 gives a one-cycle `dma_tx_go` pulse with `dma_tx_len` equal to the written value.
- R11: An access to index 9 or above reads 0, changes no state, and raises `bus_err` for one cycle alongside the read data timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Access hit an undefined index |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be taken |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmit sink takes the byte |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |
| dma_tx_addr | output | 32 | Transmit DMA address |
| dma_tx_len | output | 32 | Transmit DMA length of last start |
| dma_tx_go | output | 1 | Transmit DMA start pulse |
| dma_rx_addr | output | 32 | Receive DMA address |
| dma_rx_len | output | 32 | Receive DMA remaining length |

## Verification
The receive queue is exercised in three ways. A short burst that is drained in order shows that the queue is first-in first-out. A read of the empty queue separates the all-ones response from a real pop. A full sixteen-byte load, started from a non-zero read position, shows correct wraparound and the stall of `rx_ready` at full. The interrupt is driven one enable bit at a time: the queue bit against an empty and a non-empty queue, the transmit bit alone, and the receive bit with the DMA length set and then cleared through an address write. This isolates each term of the OR. Address aliasing above bit 11, undefined indices and a stalled transmit sink check the edges of the decode and of the streams.

// File: rtl/serport_pkg.sv
package serport_pkg;

  typedef enum logic [9:0] {
    IX_IDENT  = 10'd0,
    IX_DATA   = 10'd1,
    IX_OCC    = 10'd2,
    IX_IEN    = 10'd3,
    IX_TXADDR = 10'd4,
    IX_TXLEN  = 10'd5,
    IX_RXADDR = 10'd6,
    IX_RXLEN  = 10'd7,
    IX_DEPTH  = 10'd8
  } reg_ix_e;

  typedef struct packed {
    logic ident;
    logic data;
    logic occ;
    logic ien;
    logic txaddr;
    logic txlen;
    logic rxaddr;
    logic rxlen;
    logic depth;
    logic undef;
  } hit_t;

  localparam int IEN_W = 3;

endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  logic [9:0] ix;
  assign ix = addr[11:2];

  always_comb begin
    hit = '0;
    if (en) begin
      case (ix)
        IX_IDENT:  hit.ident  = 1'b1;
        IX_DATA:   hit.data   = 1'b1;
        IX_OCC:    hit.occ    = 1'b1;
        IX_IEN:    hit.ien    = 1'b1;
        IX_TXADDR: hit.txaddr = 1'b1;
        IX_TXLEN:  hit.txlen  = 1'b1;
        IX_RXADDR: hit.rxaddr = 1'b1;
        IX_RXLEN:  hit.rxlen  = 1'b1;
        IX_DEPTH:  hit.depth  = 1'b1;
        default:   hit.undef  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/serport_rxfifo.sv
module serport_rxfifo #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] occ
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W + 1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);

  logic [7:0]       slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W:0]   sum;
  logic [PTR_W-1:0] wr_slot;

  // write slot = read position + occupancy, folded back into range
  always_comb begin
    sum = (CNT_W + 1)'(rd_ptr) + (CNT_W + 1)'(occ);
    if (sum >= DEPTH_X) sum = sum - DEPTH_X;
    wr_slot = sum[PTR_W-1:0];
  end

  assign head = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_slot] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien,
  input  logic             q_nonempty,
  input  logic             rx_dma_idle,
  output logic             irq
);
  logic level;
  assign level = (ien[0] & q_nonempty) | ien[1] | (ien[2] & rx_dma_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= level;
  end
endmodule

// File: rtl/serport_front.sv
module serport_front
  import serport_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [31:0] ID_VALUE   = 32'h5E71_A100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              irq,
  output logic [31:0]       dma_tx_addr,
  output logic [31:0]       dma_tx_len,
  output logic              dma_tx_go,
  output logic [31:0]       dma_rx_addr,
  output logic [31:0]       dma_rx_len
);
  localparam int DEPTH_EFF = (FIFO_DEPTH <= 0) ? 16 : FIFO_DEPTH;
  localparam int CNT_W     = $clog2(DEPTH_EFF + 1);

  hit_t             hit;
  logic [7:0]       q_head;
  logic [CNT_W-1:0] occ;
  logic             q_push, q_pop, q_empty, q_full;
  logic [IEN_W-1:0] int_en;
  logic             rd_acc, wr_acc;
  logic [31:0]      rd_val;

  assign rd_acc = bus_sel & ~bus_wr;
  assign wr_acc = bus_sel &  bus_wr;

  serport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en   (bus_sel),
    .addr (bus_addr),
    .hit  (hit)
  );

  assign q_empty  = (occ == '0);
  assign q_full   = (occ == CNT_W'(DEPTH_EFF));
  assign rx_ready = (dma_rx_len == 32'd0) & ~q_full;
  assign q_push   = rx_valid & rx_ready;
  assign q_pop    = rd_acc & hit.data & ~q_empty;

  serport_rxfifo #(.DEPTH(DEPTH_EFF)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (rx_data),
    .pop       (q_pop),
    .head      (q_head),
    .occ       (occ)
  );

  serport_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ien         (int_en),
    .q_nonempty  (~q_empty),
    .rx_dma_idle (dma_rx_len == 32'd0),
    .irq         (irq)
  );

  always_comb begin
    rd_val = 32'd0;
    case (1'b1)
      hit.ident:  rd_val = ID_VALUE;
      hit.data:   rd_val = q_empty ? 32'hFFFF_FFFF : {24'd0, q_head};
      hit.occ:    rd_val = 32'(occ);
      hit.ien:    rd_val = {{(32 - IEN_W){1'b0}}, int_en};
      hit.txaddr: rd_val = dma_tx_addr;
      hit.txlen:  rd_val = 32'd0;
      hit.rxaddr: rd_val = dma_rx_addr;
      hit.rxlen:  rd_val = dma_rx_len;
      hit.depth:  rd_val = 32'(DEPTH_EFF);
      default:    rd_val = 32'd0;
    endcase
  end

  // read response path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_acc;
      bus_err    <= bus_sel & hit.undef;
      if (rd_acc) bus_rdata <= rd_val;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en      <= '0;
      dma_tx_addr <= '0;
      dma_tx_len  <= '0;
      dma_tx_go   <= 1'b0;
      dma_rx_addr <= '0;
      dma_rx_len  <= '0;
    end else begin
      dma_tx_go <= wr_acc & hit.txlen;
      if (wr_acc) begin
        if (hit.ien)    int_en      <= bus_wdata[IEN_W-1:0];
        if (hit.txaddr) dma_tx_addr <= bus_wdata;
        if (hit.txlen)  dma_tx_len  <= bus_wdata;
        if (hit.rxlen)  dma_rx_len  <= bus_wdata;
        if (hit.rxaddr) begin
          dma_rx_addr <= bus_wdata;
          dma_rx_len  <= 32'd0;
        end
      end
    end
  end

  // transmit holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (wr_acc & hit.data) begin
      tx_valid <= 1'b1;
      tx_data  <= bus_wdata[7:0];
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serport_front_chk.sv
module serport_front_chk #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              irq,
  input logic [2:0]        int_en,
  input logic [CNT_W-1:0]  occ,
  input logic [31:0]       dma_rx_addr,
  input logic [31:0]       dma_rx_len
);
  logic [9:0] ix;
  assign ix = bus_addr[11:2];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !rx_ready);

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ix == 10'd1 && occ == '0)
      |=> (bus_rvalid && bus_rdata == 32'hFFFF_FFFF));

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ix == 10'd1 && occ != '0 && !(rx_valid && rx_ready))
      |=> (occ == $past(occ) - 1'b1));

  p_irq_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_en[1] |=> irq);

  p_undef_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && ix >= 10'd9) |=> bus_err);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(bus_sel && bus_wr && ix == 10'd1))
      |=> (tx_valid && $stable(tx_data)));

  p_rxaddr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ix == 10'd6)
      |=> (dma_rx_len == 32'd0 && dma_rx_addr == $past(bus_wdata)));
endmodule

bind serport_front serport_front_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH_EFF),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .bus_err     (bus_err),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .irq         (irq),
  .int_en      (int_en),
  .occ         (occ),
  .dma_rx_addr (dma_rx_addr),
  .dma_rx_len  (dma_rx_len)
);

// File: tb/serport_front_tb.sv
module serport_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        irq;
  logic [31:0] dma_tx_addr, dma_tx_len, dma_rx_addr, dma_rx_len;
  logic        dma_tx_go;

  logic [31:0] z_rdata, z_txa, z_txl, z_rxa, z_rxl;
  logic        z_rvalid, z_err, z_rxr, z_txv, z_irq, z_go;
  logic [7:0]  z_txd;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  txexp_q[$];

  always #10 clk = ~clk;

  serport_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq),
    .dma_tx_addr(dma_tx_addr), .dma_tx_len(dma_tx_len), .dma_tx_go(dma_tx_go),
    .dma_rx_addr(dma_rx_addr), .dma_rx_len(dma_rx_len));

  serport_front #(.FIFO_DEPTH(0)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(z_rdata),
    .bus_rvalid(z_rvalid), .bus_err(z_err), .rx_valid(1'b0),
    .rx_ready(z_rxr), .rx_data(8'd0), .tx_valid(z_txv),
    .tx_ready(1'b1), .tx_data(z_txd), .irq(z_irq),
    .dma_tx_addr(z_txa), .dma_tx_len(z_txl), .dma_tx_go(z_go),
    .dma_rx_addr(z_rxa), .dma_rx_len(z_rxl));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one-cycle bus access, expected read data goes to the scoreboard
  task automatic bus_read(input logic [31:0] a, input logic [31:0] e, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor: read responses
  always @(negedge clk) begin
    if (rst_n && bus_rvalid && !done) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", bus_rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  // monitor: transmit stream
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && !done) begin
      if (txexp_q.size() == 0) check(1'b0, "R8 unexpected tx byte", {24'd0, tx_data}, 32'h0);
      else begin
        automatic logic [7:0] e = txexp_q.pop_front();
        check(tx_data === e, "R8 tx byte", {24'd0, tx_data}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(irq == 1'b0, "R9 reset irq", {31'd0, irq}, 0);
    check(rx_ready == 1'b1, "R6 reset ready", {31'd0, rx_ready}, 1);
    check(tx_valid == 1'b0, "R8 reset tx", {31'd0, tx_valid}, 0);

    // R2 fixed registers
    bus_read(32'h00, 32'h5E71_A100, "R2 ident");
    bus_read(32'h20, 32'd16, "R2 depth");
    check(z_rdata == 32'd16, "R7 zero depth forced", z_rdata, 32'd16);
    bus_read(32'h14, 32'd0, "R2 tx len reads 0");

    // R4 empty read
    bus_read(32'h04, 32'hFFFF_FFFF, "R4 empty data");
    bus_read(32'h08, 32'd0, "R4 occupancy unchanged");

    // R3 order
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    bus_read(32'h08, 32'd3, "R5 occupancy 3");
    bus_read(32'h04, 32'hA1, "R3 first");
    bus_read(32'h04, 32'hA2, "R3 second");
    bus_read(32'h04, 32'hA3, "R3 third");
    bus_read(32'h08, 32'd0, "R3 drained");

    // R9 queue term
    bus_write(32'h0C, 32'h1);
    @(negedge clk);
    check(irq == 1'b0, "R9 queue bit, empty", {31'd0, irq}, 0);
    rx_push(8'h5C);
    @(negedge clk);
    check(irq == 1'b1, "R9 queue bit, nonempty", {31'd0, irq}, 1);
    bus_read(32'h04, 32'h5C, "R3 pop");
    @(negedge clk);
    check(irq == 1'b0, "R9 queue bit after pop", {31'd0, irq}, 0);
    bus_write(32'h0C, 32'h2);
    @(negedge clk);
    check(irq == 1'b1, "R9 tx bit", {31'd0, irq}, 1);
    bus_write(32'h0C, 32'hFFFF_FFFC);
    @(negedge clk);
    check(irq == 1'b1, "R9 rx bit idle", {31'd0, irq}, 1);
    bus_read(32'h0C, 32'h4, "R9 enable readback");

    // R10 / R6 rx DMA length
    bus_write(32'h1C, 32'd5);
    @(negedge clk);
    check(irq == 1'b0, "R9 rx bit busy", {31'd0, irq}, 0);
    check(rx_ready == 1'b0, "R6 ready low during rx dma", {31'd0, rx_ready}, 0);
    bus_read(32'h1C, 32'd5, "R10 rx len");
    bus_write(32'h18, 32'h0000_0200);
    bus_read(32'h1C, 32'd0, "R10 rx len cleared");
    bus_read(32'h18, 32'h0000_0200, "R10 rx addr");
    @(negedge clk);
    check(irq == 1'b1, "R9 rx bit after clear", {31'd0, irq}, 1);

    // R5 full and wrap (read position now 4)
    for (int i = 0; i < 16; i++) rx_push(8'h10 + 8'(i));
    check(rx_ready == 1'b0, "R6 full stall", {31'd0, rx_ready}, 0);
    bus_read(32'h08, 32'd16, "R5 full occupancy");
    for (int i = 0; i < 16; i++) bus_read(32'h04, 32'h10 + 32'(i), "R5 wrap order");
    bus_read(32'h04, 32'hFFFF_FFFF, "R4 empty after wrap");

    // R1 upper bits ignored
    bus_read(32'hFFFF_F00C, 32'h4, "R1 alias enable");
    bus_read(32'h0001_2020, 32'd16, "R1 alias depth");

    // R11 undefined index
    bus_read(32'h24, 32'd0, "R11 undefined read");
    check(bus_err == 1'b1, "R11 err flag", {31'd0, bus_err}, 1);
    @(negedge clk);
    check(bus_err == 1'b0, "R11 err one cycle", {31'd0, bus_err}, 0);
    bus_write(32'hFFC, 32'h7);
    bus_read(32'h0C, 32'h4, "R11 write ignored");

    // R10 tx DMA
    bus_write(32'h10, 32'h1000_0040);
    bus_read(32'h10, 32'h1000_0040, "R10 tx addr");
    bus_write(32'h14, 32'd9);
    check(dma_tx_go == 1'b1, "R10 go pulse", {31'd0, dma_tx_go}, 1);
    check(dma_tx_len == 32'd9, "R10 go length", dma_tx_len, 32'd9);
    @(negedge clk);
    check(dma_tx_go == 1'b0, "R10 go single cycle", {31'd0, dma_tx_go}, 0);

    // R8 transmit
    txexp_q.push_back(8'hA5);
    bus_write(32'h04, 32'h0000_01A5);
    @(negedge clk);
    check(tx_valid == 1'b0, "R8 tx consumed", {31'd0, tx_valid}, 0);
    tx_ready = 1'b0;
    bus_write(32'h04, 32'h11);
    bus_write(32'h04, 32'h22);
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b1, "R8 tx held", {31'd0, tx_valid}, 1);
    check(tx_data == 8'h22, "R8 tx replaced", {24'd0, tx_data}, 32'h22);
    txexp_q.push_back(8'h22);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);

    check(exp_q.size() == 0, "R3 responses outstanding", 32'(exp_q.size()), 0);
    check(txexp_q.size() == 0, "R8 tx outstanding", 32'(txexp_q.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule